// File: doc/BRIEF.md
# Memory-to-Memory DMA Block Mover

This block copies a run of bytes from one memory region to another without help from the host processor. It has two address channels. Channel 0 walks the source and channel 1 walks the destination. Each byte is moved in two phases. A read phase loads the byte into an internal holding register, and a write phase stores that register at the destination. Each address counts up or down on its own, chosen by a direction bit. A fill option freezes the source address, so every destination byte receives the same value.

Software first writes the two base addresses, the byte count, the command and the direction bits through a small programming port. It then sets a request bit. The mover raises `hold_req` and waits for `hold_ack` from the host. It then keeps the bus and moves bytes back to back until the count runs out. When the last byte is written it pulses `eot`, sets `done` and releases hold.

The memory side is a valid/ready channel. The mover raises `mem_req` with `mem_addr`, `mem_we` and `mem_wdata`, and holds all of them unchanged until the memory answers with `mem_rdy`. A phase ends on the cycle where `mem_req` and `mem_rdy` are both high. For a read, `mem_rdata` is captured in that same cycle. The memory may stall for any number of cycles.

Top module: `dma_m2m_mover`

## Requirements
- R1: While reset is asserted and right after it, `hold_req`, `mem_req`, `eot` and `done` are low.
- R2: Programming port register numbers (`cfg_addr`):
  - 0: source base.
  - 1: destination base.
  - 2: count.
  - 3: command. Bit 0 enables the memory-to-memory mode; bit 1 selects fill.
  - 4: direction. Bit 0 makes the source decrement; bit 1 makes the destination decrement.
  - 5: request. Writing 1 to bit 0 starts a transfer.

  A request is ignored when command bit 0 is clear.
- R3: `hold_req` rises in the cycle after an accepted request. No memory request is made while `hold_ack` is low. `hold_req` falls in the cycle after the `eot` pulse.
- R4: Each byte is read at the channel 0 address. The data captured on the read handshake is then driven on `mem_wdata`, at the channel 1 address, in the cycle right after that handshake.
- R5: A transfer writes exactly count+1 bytes, so a count of 0 moves one byte.
- R6: After each byte, the source and destination addresses step by one. Each moves up, or down when its direction bit is set, independently of the other.
- R7: With fill selected, every read uses the source base address. The whole destination run then receives that one byte.
- R8: While `mem_req` is high and `mem_rdy` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values and `mem_req` stays high.
- R9: `eot` is a one-cycle pulse in the cycle after the last write handshake. `done` rises with it and stays high until the next accepted request clears it. An ignored request leaves `done` unchanged.
- R10: While a transfer runs, all programming writes, including a request, are ignored.
- R11: Take `hold_ack` as following `hold_req` one cycle later, and W as the memory wait states per phase. Then `eot` is high after 3 + 2·(count+1)·(W+1) rising edges, counting from the edge that samples the request write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Programming write strobe |
| cfg_addr | input | 3 | Programming register number |
| cfg_wdata | input | CFGW | Programming write data |
| hold_req | output | 1 | Bus hold request to the host |
| hold_ack | input | 1 | Host grants the bus |
| mem_req | output | 1 | Memory request valid |
| mem_rdy | input | 1 | Memory ready; a handshake occurs when both are high |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data, taken from the holding register |
| mem_rdata | input | DW | Read data, valid on the read handshake |
| eot | output | 1 | End-of-transfer pulse |
| done | output | 1 | Completion status flag |

## Verification
The host grant takes one cycle. Reaching the first read then takes a second edge. After that, each phase lasts W+1 cycles, and `eot` comes on the edge after the final write handshake. The bench counts rising edges from the request edge and compares the total with the R11 formula. It samples `eot` only at falling edges. `hold_req` must fall and `done` must be high one cycle after the pulse, and the bench samples both at the following falling edge. Memory contents are compared only once the transfer has finished. A `done` clear is checked at the first falling edge after an accepted request.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RD,
    ST_WR,
    ST_FIN
  } mover_state_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_CMD  = 3'd3;
  localparam logic [2:0] REG_DIR  = 3'd4;
  localparam logic [2:0] REG_REQ  = 3'd5;

  localparam int NUM_CHAN = 2;

  typedef struct packed {
    logic fill;
    logic mm_en;
  } mover_cmd_t;
endpackage

// File: rtl/dma_m2m_regs.sv
module dma_m2m_regs
  import dma_m2m_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int CFGW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            busy_i,
  output logic [AW-1:0]   src_base_o,
  output logic [AW-1:0]   dst_base_o,
  output logic [CW-1:0]   cnt_base_o,
  output mover_cmd_t      cmd_o,
  output logic            src_dec_o,
  output logic            dst_dec_o,
  output logic            start_o
);
  logic wr_ok;
  assign wr_ok = cfg_we && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base_o <= '0;
      dst_base_o <= '0;
      cnt_base_o <= '0;
      cmd_o      <= '0;
      src_dec_o  <= 1'b0;
      dst_dec_o  <= 1'b0;
    end else if (wr_ok) begin
      unique case (cfg_addr)
        REG_SRC: src_base_o <= cfg_wdata[AW-1:0];
        REG_DST: dst_base_o <= cfg_wdata[AW-1:0];
        REG_CNT: cnt_base_o <= cfg_wdata[CW-1:0];
        REG_CMD: begin
          cmd_o.mm_en <= cfg_wdata[0];
          cmd_o.fill  <= cfg_wdata[1];
        end
        REG_DIR: begin
          src_dec_o <= cfg_wdata[0];
          dst_dec_o <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  assign start_o = wr_ok && (cfg_addr == REG_REQ) && cfg_wdata[0] && cmd_o.mm_en;
endmodule

// File: rtl/dma_m2m_addr_chan.sv
module dma_m2m_addr_chan #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          dec_i,
  output logic [AW-1:0] cur_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_o <= '0;
    else if (load_i)
      cur_o <= base_i;
    else if (step_i)
      cur_o <= dec_i ? cur_o - 1'b1 : cur_o + 1'b1;
  end
endmodule

// File: rtl/dma_m2m_seq.sv
module dma_m2m_seq
  import dma_m2m_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cnt_base_i,
  input  logic          fill_i,
  input  logic          hold_ack,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata,
  output logic          hold_req,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          src_step_o,
  output logic          dst_step_o,
  output logic          busy_o,
  output logic          eot,
  output logic          done
);
  mover_state_t state_q, state_d;
  logic [CW-1:0] remain_q;
  logic [DW-1:0] hold_byte_q;
  logic          rd_hs, wr_hs, last_byte;

  assign rd_hs     = (state_q == ST_RD) && mem_rdy;
  assign wr_hs     = (state_q == ST_WR) && mem_rdy;
  assign last_byte = (remain_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)  state_d = ST_HOLD;
      ST_HOLD: if (hold_ack) state_d = ST_RD;
      ST_RD:   if (mem_rdy)  state_d = ST_WR;
      ST_WR:   if (mem_rdy)  state_d = last_byte ? ST_FIN : ST_RD;
      ST_FIN:                state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      remain_q    <= '0;
      hold_byte_q <= '0;
      done        <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i && state_q == ST_IDLE) begin
        remain_q <= cnt_base_i;
        done     <= 1'b0;
      end else if (wr_hs && !last_byte) begin
        remain_q <= remain_q - 1'b1;
      end
      if (rd_hs)
        hold_byte_q <= mem_rdata;
      if (wr_hs && last_byte)
        done <= 1'b1;
    end
  end

  assign hold_req   = (state_q != ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req    = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we     = (state_q == ST_WR);
  assign mem_wdata  = hold_byte_q;
  assign eot        = (state_q == ST_FIN);
  assign src_step_o = rd_hs && !fill_i;
  assign dst_step_o = wr_hs;
endmodule

// File: rtl/dma_m2m_mover.sv
module dma_m2m_mover
  import dma_m2m_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int CFGW = (AW > CW) ? AW : CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [CFGW-1:0] cfg_wdata,
  output logic            hold_req,
  input  logic            hold_ack,
  output logic            mem_req,
  input  logic            mem_rdy,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            eot,
  output logic            done
);
  logic [AW-1:0] src_base, dst_base;
  logic [CW-1:0] cnt_base;
  mover_cmd_t    cmd;
  logic          src_dec, dst_dec, start, busy, src_step, dst_step;

  logic [AW-1:0] ch_base [NUM_CHAN];
  logic          ch_step [NUM_CHAN];
  logic          ch_dec  [NUM_CHAN];
  logic [AW-1:0] ch_cur  [NUM_CHAN];

  dma_m2m_regs #(.AW(AW), .CW(CW), .CFGW(CFGW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .busy_i     (busy),
    .src_base_o (src_base),
    .dst_base_o (dst_base),
    .cnt_base_o (cnt_base),
    .cmd_o      (cmd),
    .src_dec_o  (src_dec),
    .dst_dec_o  (dst_dec),
    .start_o    (start)
  );

  assign ch_base[0] = src_base;
  assign ch_base[1] = dst_base;
  assign ch_step[0] = src_step;
  assign ch_step[1] = dst_step;
  assign ch_dec[0]  = src_dec;
  assign ch_dec[1]  = dst_dec;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    dma_m2m_addr_chan #(.AW(AW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .base_i (ch_base[g]),
      .step_i (ch_step[g]),
      .dec_i  (ch_dec[g]),
      .cur_o  (ch_cur[g])
    );
  end

  dma_m2m_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cnt_base_i (cnt_base),
    .fill_i     (cmd.fill),
    .hold_ack   (hold_ack),
    .mem_rdy    (mem_rdy),
    .mem_rdata  (mem_rdata),
    .hold_req   (hold_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .src_step_o (src_step),
    .dst_step_o (dst_step),
    .busy_o     (busy),
    .eot        (eot),
    .done       (done)
  );

  assign mem_addr = mem_we ? ch_cur[1] : ch_cur[0];
endmodule

// File: rtl/dma_m2m_mover_chk.sv
module dma_m2m_mover_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          mem_req,
  input logic          mem_rdy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          eot,
  input logic          done
);
  assert_mem_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (hold_req && hold_ack));

  assert_hold_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !hold_req);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rdy && !mem_we) |=> (mem_req && mem_we));

  assert_eot_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot);

  assert_eot_sets_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> done);
endmodule

bind dma_m2m_mover dma_m2m_mover_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_req  (hold_req),
  .hold_ack  (hold_ack),
  .mem_req   (mem_req),
  .mem_rdy   (mem_rdy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .eot       (eot),
  .done      (done)
);

// File: tb/dma_m2m_mover_tb_top.sv
module dma_m2m_mover_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 16;

  typedef struct packed {
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] cnt;
    logic       fill;
    logic       sdec;
    logic       ddec;
    logic [1:0] wt;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h10, 8'h40, 8'd3, 1'b0, 1'b0, 1'b0, 2'd0},
    '{8'h20, 8'h60, 8'd0, 1'b0, 1'b0, 1'b0, 2'd1},
    '{8'h30, 8'h80, 8'd4, 1'b1, 1'b0, 1'b0, 2'd0},
    '{8'h5F, 8'h9F, 8'd5, 1'b0, 1'b1, 1'b1, 2'd2},
    '{8'h40, 8'hA0, 8'd2, 1'b0, 1'b1, 1'b0, 2'd1},
    '{8'h70, 8'h72, 8'd3, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          hold_req, hold_ack = 1'b0;
  logic          mem_req, mem_rdy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          eot, done;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic       mem_init = 1'b0;
  int         wr_cnt = 0;
  int         wcnt = 0;
  int         wt_cfg = 0;
  int         stall_err = 0;
  logic       stall_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic       we_prev = 1'b0;
  logic [DW-1:0] wd_prev = '0;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  dma_m2m_mover #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .hold_req  (hold_req),
    .hold_ack  (hold_ack),
    .mem_req   (mem_req),
    .mem_rdy   (mem_rdy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .eot       (eot),
    .done      (done)
  );

  assign mem_rdy   = mem_req && (wcnt >= wt_cfg);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    hold_ack <= hold_req;
    if (mem_req && !mem_rdy) wcnt <= wcnt + 1;
    else                     wcnt <= 0;
    if (stall_prev && (mem_addr != addr_prev || mem_we != we_prev ||
                       mem_wdata != wd_prev || !mem_req))
      stall_err <= stall_err + 1;
    stall_prev <= mem_req && !mem_rdy;
    addr_prev  <= mem_addr;
    we_prev    <= mem_we;
    wd_prev    <= mem_wdata;
    if (mem_init) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      wr_cnt <= 0;
    end else if (mem_req && mem_rdy && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  task automatic reset_mem();
    @(negedge clk) mem_init = 1'b1;
    @(negedge clk) mem_init = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i * 7 + 3);
  endtask

  task automatic prog(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ref_copy(input vec_t v);
    for (int i = 0; i <= int'(v.cnt); i++) begin
      logic [7:0] s, d;
      s = v.fill ? v.src : (v.sdec ? v.src - 8'(i) : v.src + 8'(i));
      d = v.ddec ? v.dst - 8'(i) : v.dst + 8'(i);
      ref_mem[d] = ref_mem[s];
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) n++;
    return n;
  endfunction

  task automatic setup(input vec_t v);
    wt_cfg = int'(v.wt);
    prog(3'd0, {8'h00, v.src});
    prog(3'd1, {8'h00, v.dst});
    prog(3'd2, {8'h00, v.cnt});
    prog(3'd3, {14'd0, v.fill, 1'b1});
    prog(3'd4, {14'd0, v.ddec, v.sdec});
  endtask

  task automatic wait_eot(output int cyc);
    cyc = 0;
    while (!eot && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
  endtask

  initial begin
    int cyc, exp_cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!hold_req && !mem_req && !eot && !done, "R1 in reset", {hold_req, mem_req, eot, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hold_req && !mem_req && !eot && !done, "R1 after reset", {hold_req, mem_req, eot, done}, 0);

    // table of vectors: R4 R5 R6 R7 R9 R11
    for (int k = 0; k < NVEC; k++) begin
      reset_mem();
      setup(VECS[k]);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 16'd1;
      wait_eot(cyc);
      exp_cyc = 3 + 2 * (int'(VECS[k].cnt) + 1) * (int'(VECS[k].wt) + 1);
      check(cyc == exp_cyc, "R11 eot cycle", cyc, exp_cyc);
      check(done === 1'b1, "R9 done with eot", int'(done), 1);
      @(negedge clk);
      check(!hold_req && !eot, "R3/R9 hold released, single eot", {hold_req, eot}, 0);
      check(wr_cnt == int'(VECS[k].cnt) + 1, "R5 byte count", wr_cnt, int'(VECS[k].cnt) + 1);
      ref_copy(VECS[k]);
      check(mem_diff() == 0, VECS[k].fill ? "R7 fill contents" : "R4/R6 copy contents", mem_diff(), 0);
    end
    check(stall_err == 0, "R8 stall stability", stall_err, 0);

    // R2: request ignored when mode disabled; R9 done unchanged
    reset_mem();
    prog(3'd3, 16'd0);
    prog(3'd5, 16'd1);
    repeat (6) @(negedge clk);
    check(!hold_req && !mem_req, "R2 request ignored", {hold_req, mem_req}, 0);
    check(done === 1'b1, "R9 done kept on ignored request", int'(done), 1);
    check(mem_diff() == 0, "R2 memory untouched", mem_diff(), 0);

    // R10: writes during busy ignored; R9 done cleared by start
    reset_mem();
    setup(VECS[0]);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 16'd1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(done === 1'b0 && hold_req, "R9 done cleared, R3 hold raised", {done, hold_req}, 1);
    repeat (3) @(negedge clk);
    prog(3'd0, 16'h00C0);
    prog(3'd5, 16'd1);
    wait_eot(cyc);
    @(negedge clk);
    ref_copy(VECS[0]);
    check(mem_diff() == 0, "R10 busy writes ignored", mem_diff(), 0);
    check(wr_cnt == 4, "R10 no restart", wr_cnt, 4);
    repeat (4) @(negedge clk);
    check(!hold_req, "R10 stays idle", int'(hold_req), 0);
    finish_run();
  end
endmodule